// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block produces the array address for a synchronous burst memory. An access begins when either of two address strobes is high at a rising clock edge. On that edge the block captures a full starting address and the order select, and it clears its beat count. After that, each edge with the advance input high moves the burst to its next beat. The low address bits step through a block of four aligned addresses and wrap back to the first one. The upper address bits do not change until the next strobe.

Two beat orders are available. In the interleaved order, the low bits are the starting offset XOR the beat count. In the linear order, the low bits are the starting offset plus the beat count, modulo four. The order select is read only at the load edge, so each burst keeps the order it started with.

The memory array and the chip-select decoding are outside this block. The address output is formed from registered state, so it shows the new value in the same cycle that follows the load or advance edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, `addr_out` is all zeros and `beat_cnt` is 0.
- R2: An edge with `strobe_cpu` or `strobe_ctl` high loads the burst. After that edge, `addr_out` equals the `addr_in` sampled on the edge and `beat_cnt` is 0. The two strobes behave the same.
- R3: A strobe takes priority over `adv_en`. A strobe that arrives in the middle of a burst restarts the burst from the new address with `beat_cnt` at 0.
- R4: An edge with `adv_en` high and both strobes low raises `beat_cnt` by one, modulo 4.
- R5: An edge with both strobes low and `adv_en` low leaves `addr_out` and `beat_cnt` unchanged.
- R6: `addr_out` bits above bit 1 keep the value loaded by the last strobe for the whole burst.
- R7: When `order_sel` was 1 at the load edge (interleaved), `addr_out[1:0]` equals the start offset XOR `beat_cnt`. A start offset of 01 gives 01, 00, 11, 10.
- R8: When `order_sel` was 0 at the load edge (linear), `addr_out[1:0]` equals (start offset + `beat_cnt`) mod 4. A start offset of 01 gives 01, 10, 11, 00.
- R9: A change of `order_sel` on an edge without a strobe has no effect on the burst in progress.
- R10: After four advances, `addr_out` is back at the starting address in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_cpu | input | 1 | First address strobe; loads a burst |
| strobe_ctl | input | 1 | Second address strobe; loads a burst |
| adv_en | input | 1 | Moves the burst to its next beat |
| order_sel | input | 1 | Beat order captured at load: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | Starting address of the burst |
| addr_out | output | ADDR_W | Current array address |
| beat_cnt | output | BURST_BITS | Beats advanced since the load |

## Verification
The bench builds the block with `ADDR_W` = 10, `BURST_BITS` = 2 and the order policy that reads the select pin. With these values both beat orders can be reached from one instance. The address is narrow enough that random starting addresses often repeat upper fields and often hit every low offset. Directed bursts check the sequences from start offset 01, the wrap after four beats, a reload in the middle of a burst, and a change of the order select in the middle of a burst. Random cycles then mix strobes, advances, holds and order changes.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // How the beat order is chosen: read from the pin at each load, or fixed
   typedef enum logic [1:0] {
      ORD_PIN    = 2'd0,
      ORD_LINEAR = 2'd1,
      ORD_XOR    = 2'd2
   } order_policy_e;

   localparam logic ORDER_LINEAR = 1'b0;
   localparam logic ORDER_XOR    = 1'b1;

endpackage

// File: rtl/burst_load_reg.sv
module burst_load_reg #(
   parameter int ADDR_W     = 18,
   parameter int BURST_BITS = 2,
   localparam int HI_W      = ADDR_W - BURST_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              order_in,
   output logic [HI_W-1:0]   base_hi,
   output logic [BURST_BITS-1:0] start_lo,
   output logic              order_q
);

   // Captures the fixed part of the burst; only a strobe edge changes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi  <= '0;
         start_lo <= '0;
         order_q  <= 1'b0;
      end else if (load) begin
         base_hi  <= addr_in[ADDR_W-1:BURST_BITS];
         start_lo <= addr_in[BURST_BITS-1:0];
         order_q  <= order_in;
      end
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  adv,
   output logic [BURST_BITS-1:0] cnt
);

   localparam logic [BURST_BITS-1:0] ONE = {{(BURST_BITS-1){1'b0}}, 1'b1};

   // Load clears, advance steps; natural overflow gives the wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_addr_pkg::*;
#(
   parameter int            BURST_BITS   = 2,
   parameter order_policy_e ORDER_POLICY = ORD_PIN
) (
   input  logic [BURST_BITS-1:0] start_lo,
   input  logic [BURST_BITS-1:0] cnt,
   input  logic                  order_q,
   output logic [BURST_BITS-1:0] offset
);

   logic [BURST_BITS-1:0] lin_off;
   logic [BURST_BITS-1:0] xor_off;

   assign lin_off = start_lo + cnt;
   assign xor_off = start_lo ^ cnt;

   generate
      if (ORDER_POLICY == ORD_LINEAR) begin : g_fixed_lin
         logic unused_order;
         assign unused_order = order_q;
         assign offset = lin_off;
      end else if (ORDER_POLICY == ORD_XOR) begin : g_fixed_xor
         logic unused_order;
         assign unused_order = order_q;
         assign offset = xor_off;
      end else begin : g_pin
         assign offset = (order_q == ORDER_XOR) ? xor_off : lin_off;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int            ADDR_W       = 18,
   parameter int            BURST_BITS   = 2,
   parameter order_policy_e ORDER_POLICY = ORD_PIN
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  strobe_cpu,
   input  logic                  strobe_ctl,
   input  logic                  adv_en,
   input  logic                  order_sel,
   input  logic [ADDR_W-1:0]     addr_in,
   output logic [ADDR_W-1:0]     addr_out,
   output logic [BURST_BITS-1:0] beat_cnt
);

   localparam int HI_W = ADDR_W - BURST_BITS;

   generate
      if (BURST_BITS < 1) begin : g_bad_bits
         $error("burst_addr_gen: BURST_BITS must be at least 1");
      end
      if (ADDR_W <= BURST_BITS) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W must exceed BURST_BITS");
      end
   endgenerate

   logic                  load;
   logic [HI_W-1:0]       base_hi;
   logic [BURST_BITS-1:0] start_lo;
   logic                  order_q;
   logic [BURST_BITS-1:0] cnt;
   logic [BURST_BITS-1:0] offset;

   assign load = strobe_cpu | strobe_ctl;

   burst_load_reg #(
      .ADDR_W     (ADDR_W),
      .BURST_BITS (BURST_BITS)
   ) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .addr_in  (addr_in),
      .order_in (order_sel),
      .base_hi  (base_hi),
      .start_lo (start_lo),
      .order_q  (order_q)
   );

   burst_beat_ctr #(
      .BURST_BITS (BURST_BITS)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .adv   (adv_en),
      .cnt   (cnt)
   );

   burst_order_map #(
      .BURST_BITS   (BURST_BITS),
      .ORDER_POLICY (ORDER_POLICY)
   ) u_map (
      .start_lo (start_lo),
      .cnt      (cnt),
      .order_q  (order_q),
      .offset   (offset)
   );

   assign addr_out = {base_hi, offset};
   assign beat_cnt = cnt;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
   import burst_addr_pkg::*;
#(
   parameter int            ADDR_W       = 18,
   parameter int            BURST_BITS   = 2,
   parameter order_policy_e ORDER_POLICY = ORD_PIN
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  strobe_cpu,
   input logic                  strobe_ctl,
   input logic                  adv_en,
   input logic                  order_sel,
   input logic [ADDR_W-1:0]     addr_in,
   input logic [ADDR_W-1:0]     addr_out,
   input logic [BURST_BITS-1:0] beat_cnt
);

   localparam logic [BURST_BITS-1:0] ONE = {{(BURST_BITS-1){1'b0}}, 1'b1};

   logic                  strb;
   logic [BURST_BITS-1:0] chk_start;
   logic                  chk_xor;
   logic [BURST_BITS-1:0] lo;

   assign strb = strobe_cpu | strobe_ctl;
   assign lo   = addr_out[BURST_BITS-1:0];

   // Checker's own record of the burst start offset and the chosen order
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_start <= '0;
         chk_xor   <= (ORDER_POLICY == ORD_XOR);
      end else if (strb) begin
         chk_start <= addr_in[BURST_BITS-1:0];
         chk_xor   <= (ORDER_POLICY == ORD_PIN) ? order_sel : (ORDER_POLICY == ORD_XOR);
      end
   end

   always_comb begin
      if (!rst_n) begin
         assert_reset_R1: assert (addr_out == '0 && beat_cnt == '0);
      end
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      strb |=> (addr_out == $past(addr_in) && beat_cnt == '0));

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && adv_en) |=> beat_cnt == '0);

   assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb && adv_en) |=> beat_cnt == $past(beat_cnt) + ONE);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb && !adv_en) |=> ($stable(addr_out) && $stable(beat_cnt)));

   assert_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !strb |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));

   assert_xor_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_xor |-> lo == (chk_start ^ beat_cnt));

   assert_lin_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_xor |-> lo == BURST_BITS'(chk_start + beat_cnt));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
   .ADDR_W       (ADDR_W),
   .BURST_BITS   (BURST_BITS),
   .ORDER_POLICY (ORDER_POLICY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strobe_cpu (strobe_cpu),
   .strobe_ctl (strobe_ctl),
   .adv_en     (adv_en),
   .order_sel  (order_sel),
   .addr_in    (addr_in),
   .addr_out   (addr_out),
   .beat_cnt   (beat_cnt)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
   import burst_addr_pkg::*;

   localparam int AW = 10;
   localparam int BB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe_cpu = 1'b0, strobe_ctl = 1'b0, adv_en = 1'b0, order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [BB-1:0] beat_cnt;

   int n_checks = 0;
   int n_fail   = 0;

   // Reference state of the bench
   logic [AW-1:0] m_base = '0;
   int            m_cnt  = 0;
   bit            m_xor  = 1'b0;

   always #2 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(BB), .ORDER_POLICY(ORD_PIN)) dut (
      .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
      .adv_en(adv_en), .order_sel(order_sel), .addr_in(addr_in),
      .addr_out(addr_out), .beat_cnt(beat_cnt));

   function automatic logic [AW-1:0] exp_addr();
      logic [1:0] s, c, o;
      s = m_base[1:0];
      c = 2'(m_cnt);
      o = m_xor ? (s ^ c) : 2'(s + c);
      return {m_base[AW-1:2], o};
   endfunction

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // One clock: drive at falling edge, update model at rising edge, compare after it
   task automatic cyc(input bit sc, input bit sk, input bit adv, input bit ord,
                      input logic [AW-1:0] a, input string rq);
      @(negedge clk);
      strobe_cpu = sc; strobe_ctl = sk; adv_en = adv; order_sel = ord; addr_in = a;
      @(posedge clk);
      if (sc || sk) begin
         m_base = a; m_cnt = 0; m_xor = ord;
      end else if (adv) begin
         m_cnt = (m_cnt + 1) % 4;
      end
      #1;
      check(addr_out == exp_addr(), rq, int'(addr_out), int'(exp_addr()));
      check(int'(beat_cnt) == m_cnt, rq, int'(beat_cnt), m_cnt);
   endtask

   initial begin
      #(4 * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [1:0] xor_seq [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
      logic [1:0] lin_seq [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
      void'($urandom(32'h5EED_1234));

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(addr_out == '0, "R1", int'(addr_out), 0);
      check(beat_cnt == '0, "R1", int'(beat_cnt), 0);
      @(negedge clk); rst_n = 1'b1;

      // R7: interleaved order from offset 01, then R10 wrap
      cyc(1, 0, 0, 1, 10'h2A5, "R2");
      check(addr_out[1:0] == xor_seq[0], "R7", int'(addr_out[1:0]), int'(xor_seq[0]));
      for (int i = 1; i < 4; i++) begin
         cyc(0, 0, 1, 1, 10'h000, "R7");
         check(addr_out[1:0] == xor_seq[i], "R7", int'(addr_out[1:0]), int'(xor_seq[i]));
         check(addr_out[AW-1:2] == 8'hA9, "R6", int'(addr_out[AW-1:2]), 'hA9);
      end
      cyc(0, 0, 1, 0, 10'h3FF, "R10");
      check(addr_out == 10'h2A5, "R10", int'(addr_out), 'h2A5);

      // R8: linear order from offset 01 via the second strobe; mode flips mid-burst (R9)
      cyc(0, 1, 0, 0, 10'h131, "R2");
      check(addr_out == 10'h131, "R2", int'(addr_out), 'h131);
      for (int i = 1; i < 4; i++) begin
         cyc(0, 0, 1, 1, 10'h000, "R9");
         check(addr_out[1:0] == lin_seq[i], "R8", int'(addr_out[1:0]), int'(lin_seq[i]));
      end
      cyc(0, 0, 1, 1, 10'h000, "R10");
      check(addr_out == 10'h131, "R10", int'(addr_out), 'h131);

      // R5: hold with advance low
      cyc(0, 0, 1, 0, 10'h0, "R4");
      repeat (3) cyc(0, 0, 0, 1, 10'h3C3, "R5");
      check(addr_out == 10'h132, "R5", int'(addr_out), 'h132);

      // R3: strobe with advance high in the middle of a burst
      cyc(1, 0, 1, 1, 10'h0F2, "R3");
      check(beat_cnt == 2'd0, "R3", int'(beat_cnt), 0);
      check(addr_out == 10'h0F2, "R3", int'(addr_out), 'h0F2);
      cyc(0, 0, 1, 0, 10'h0, "R7");
      check(addr_out == 10'h0F3, "R7", int'(addr_out), 'h0F3);

      // Random mix: strobes, advances, holds and order changes (R4 R5 R9)
      for (int k = 0; k < 600; k++) begin
         bit sc, sk, adv, ord;
         sc  = ($urandom % 8) == 0;
         sk  = ($urandom % 8) == 0;
         adv = $urandom % 2;
         ord = $urandom % 2;
         cyc(sc, sk, adv, ord, AW'($urandom), "R4_R5_R9_random");
      end

      finish_run();
   end

endmodule